// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Butterfly

This block is the arithmetic core of one stage of a pipelined radix-2 FFT that splits by frequency. It takes two complex samples, an upper one and a lower one, each given as separate signed real and imaginary words. It also takes one twiddle factor W = C + jS. It returns the sum of the two samples and the difference of the two samples rotated by W. The twiddle arrives in a pre-processed form, as the cosine term C, the difference C−S and the sum C+S. Those values come from a coefficient table outside the block. With them, the rotation needs only three real multipliers and three real additions.

The datapath is a fixed four-register pipeline. It takes a new butterfly on every clock that has the input valid high. A valid flag travels with each butterfly and leaves with its results. A parameter picks whether both outputs are halved, which stops word growth from stage to stage. Every result is rounded and then clamped to the data width. Address generation, the coefficient table and the sample memories belong to the surrounding FFT stage.

Top module: `dif_butterfly`

## Requirements
- R1: With HALVE=1, each sum output equals (upper + lower) in that component, with 1 added and then shifted arithmetically right by one bit (round half up). For example, 1+0 gives 1 and −1+0 gives 0.
- R2: With d = upper − lower = a + jb, the rotated output is d·(C + jS). The real part is a·C − b·S and the imaginary part is a·S + b·C. C is signed Q1.15 on twCos. C−S and C+S are signed 17-bit words with 15 fraction bits, on twDiff and twSum. Each product is rounded half up and shifted right by 15 + HALVE bits.
- R3: Any result that falls outside the signed DW-bit range is clamped to +2^(DW−1)−1 or −2^(DW−1), with no wrap-around.
- R4: A butterfly sampled with inValid high at a rising edge appears at the outputs, with outValid high, after the fourth rising edge counted from and including that one. outValid is never high unless inValid was high four edges earlier. Back-to-back inputs give back-to-back outputs.
- R5: While outValid is low, all four result outputs hold their previous values.
- R6: While rst is high (synchronous, active high), outValid and all result outputs go to zero on the next edge.
- R7: With HALVE=0, the sums are not scaled (only clamped), and the products are shifted right by 15 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks a butterfly on the inputs this cycle |
| topRe | input | DW | Upper sample, real part |
| topIm | input | DW | Upper sample, imaginary part |
| botRe | input | DW | Lower sample, real part |
| botIm | input | DW | Lower sample, imaginary part |
| twCos | input | CW | Twiddle C, Q1.15 |
| twDiff | input | CW+1 | Twiddle C−S |
| twSum | input | CW+1 | Twiddle C+S |
| outValid | output | 1 | Results are valid this cycle |
| sumRe | output | DW | Upper result, real part |
| sumIm | output | DW | Upper result, imaginary part |
| rotRe | output | DW | Rotated difference, real part |
| rotIm | output | DW | Rotated difference, imaginary part |

## Verification
On every cycle, the bound assertions check the four-cycle valid latency, the absence of spurious valids, the holding of results while idle, the clearing on reset, and the rounded real sum against a delayed copy of the inputs. The rotation arithmetic is the three-multiplier identity, and the properties cannot state it cheaply. So the bench's scenarios show it instead: they compare the rotation against a direct four-product reference. Those scenarios also cover the clamping at extreme operands and the rounding of negative halves. They run the unscaled variant from the same stimulus, so the bench checks both settings of the scaling parameter.

// File: rtl/dif_bfly_pkg.sv
package dif_bfly_pkg;
  localparam int LATENCY = 4;

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic ld4;
  } stage_stb_t;
endpackage

// File: rtl/dif_bfly_ctrl.sv
module dif_bfly_ctrl
  import dif_bfly_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output stage_stb_t stb,
  output logic       outValid
);
  logic [LATENCY-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[LATENCY-2:0], inValid};
  end

  // each stage loads only when the butterfly ahead of it is valid
  assign stb.ld1  = inValid;
  assign stb.ld2  = vPipe[0];
  assign stb.ld3  = vPipe[1];
  assign stb.ld4  = vPipe[2];
  assign outValid = vPipe[LATENCY-1];
endmodule

// File: rtl/dif_bfly_datapath.sv
module dif_bfly_datapath
  import dif_bfly_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter bit HALVE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  stage_stb_t           stb,
  input  logic signed [DW-1:0] topRe,
  input  logic signed [DW-1:0] topIm,
  input  logic signed [DW-1:0] botRe,
  input  logic signed [DW-1:0] botIm,
  input  logic signed [CW-1:0] twCos,
  input  logic signed [CW:0]   twDiff,
  input  logic signed [CW:0]   twSum,
  output logic signed [DW-1:0] sumRe,
  output logic signed [DW-1:0] sumIm,
  output logic signed [DW-1:0] rotRe,
  output logic signed [DW-1:0] rotIm
);
  localparam int AW  = DW + 1;        // sum / difference width
  localparam int DDW = DW + 2;        // a - b width
  localparam int KW  = CW + 1;        // pre-combined coefficient width
  localparam int PW  = DW + CW + 3;   // product width with headroom
  localparam int SW  = PW + 1;        // rotated accumulation width
  localparam int SH  = CW - 1 + int'(HALVE);

  localparam logic signed [SW-1:0] RND_P = SW'(64'sd1 <<< (SH - 1));
  localparam logic signed [SW-1:0] MAX_P = SW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MIN_P = -MAX_P - SW'(1);
  localparam logic signed [AW-1:0] MAX_A = AW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MIN_A = -MAX_A - AW'(1);

  function automatic logic signed [DW-1:0] roundSatP(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] r;
    r = (v + RND_P) >>> SH;
    if (r > MAX_P)      return MAX_P[DW-1:0];
    else if (r < MIN_P) return MIN_P[DW-1:0];
    else                return r[DW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] satA(input logic signed [AW-1:0] v);
    if (v > MAX_A)      return MAX_A[DW-1:0];
    else if (v < MIN_A) return MIN_A[DW-1:0];
    else                return v[DW-1:0];
  endfunction

  // stage 1: sums, differences, coefficient capture
  logic signed [AW-1:0] s1SumRe, s1SumIm, s1A, s1B;
  logic signed [CW-1:0] s1Cos;
  logic signed [KW-1:0] s1Diff, s1Sum;

  always_ff @(posedge clk) begin
    if (stb.ld1) begin
      s1SumRe <= AW'(topRe) + AW'(botRe);
      s1SumIm <= AW'(topIm) + AW'(botIm);
      s1A     <= AW'(topRe) - AW'(botRe);
      s1B     <= AW'(topIm) - AW'(botIm);
      s1Cos   <= twCos;
      s1Diff  <= twDiff;
      s1Sum   <= twSum;
    end
  end

  // stage 2: shared term a - b
  logic signed [AW-1:0]  s2SumRe, s2SumIm, s2A, s2B;
  logic signed [DDW-1:0] s2D;
  logic signed [CW-1:0]  s2Cos;
  logic signed [KW-1:0]  s2Diff, s2Sum;

  always_ff @(posedge clk) begin
    if (stb.ld2) begin
      s2SumRe <= s1SumRe;
      s2SumIm <= s1SumIm;
      s2A     <= s1A;
      s2B     <= s1B;
      s2D     <= DDW'(s1A) - DDW'(s1B);
      s2Cos   <= s1Cos;
      s2Diff  <= s1Diff;
      s2Sum   <= s1Sum;
    end
  end

  // stage 3: the three real multiplications
  logic signed [AW-1:0] s3SumRe, s3SumIm;
  logic signed [PW-1:0] s3Z, s3Pr, s3Pi;

  always_ff @(posedge clk) begin
    if (stb.ld3) begin
      s3SumRe <= s2SumRe;
      s3SumIm <= s2SumIm;
      s3Z     <= PW'(s2D) * PW'(s2Cos);
      s3Pr    <= PW'(s2B) * PW'(s2Diff);
      s3Pi    <= PW'(s2A) * PW'(s2Sum);
    end
  end

  // stage 4: final additions, scaling, rounding and clamping
  logic signed [SW-1:0] rotReFull, rotImFull;
  logic signed [AW-1:0] sumReAdj, sumImAdj;

  assign rotReFull = SW'(s3Z) + SW'(s3Pr);
  assign rotImFull = SW'(s3Pi) - SW'(s3Z);

  generate
    if (HALVE) begin : g_halve
      assign sumReAdj = (s3SumRe + AW'(1)) >>> 1;
      assign sumImAdj = (s3SumIm + AW'(1)) >>> 1;
    end else begin : g_full
      assign sumReAdj = s3SumRe;
      assign sumImAdj = s3SumIm;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sumRe <= '0;
      sumIm <= '0;
      rotRe <= '0;
      rotIm <= '0;
    end else if (stb.ld4) begin
      sumRe <= satA(sumReAdj);
      sumIm <= satA(sumImAdj);
      rotRe <= roundSatP(rotReFull);
      rotIm <= roundSatP(rotImFull);
    end
  end
endmodule

// File: rtl/dif_butterfly.sv
module dif_butterfly
  import dif_bfly_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter bit HALVE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [DW-1:0] topRe,
  input  logic signed [DW-1:0] topIm,
  input  logic signed [DW-1:0] botRe,
  input  logic signed [DW-1:0] botIm,
  input  logic signed [CW-1:0] twCos,
  input  logic signed [CW:0]   twDiff,
  input  logic signed [CW:0]   twSum,
  output logic                 outValid,
  output logic signed [DW-1:0] sumRe,
  output logic signed [DW-1:0] sumIm,
  output logic signed [DW-1:0] rotRe,
  output logic signed [DW-1:0] rotIm
);
  stage_stb_t stb;

  dif_bfly_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  dif_bfly_datapath #(.DW(DW), .CW(CW), .HALVE(HALVE)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .topRe  (topRe),
    .topIm  (topIm),
    .botRe  (botRe),
    .botIm  (botIm),
    .twCos  (twCos),
    .twDiff (twDiff),
    .twSum  (twSum),
    .sumRe  (sumRe),
    .sumIm  (sumIm),
    .rotRe  (rotRe),
    .rotIm  (rotIm)
  );
endmodule

// File: rtl/dif_butterfly_chk.sv
module dif_butterfly_chk
  import dif_bfly_pkg::*;
#(
  parameter int DW    = 16,
  parameter bit HALVE = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 inValid,
  input logic signed [DW-1:0] topRe,
  input logic signed [DW-1:0] botRe,
  input logic                 outValid,
  input logic signed [DW-1:0] sumRe,
  input logic signed [DW-1:0] sumIm,
  input logic signed [DW-1:0] rotRe,
  input logic signed [DW-1:0] rotIm
);
  localparam int AW = DW + 1;
  localparam logic signed [AW-1:0] HI = AW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [AW-1:0] LO = -HI - AW'(1);

  // independent delay line of the real inputs
  logic signed [DW-1:0] dTop [LATENCY];
  logic signed [DW-1:0] dBot [LATENCY];

  always_ff @(posedge clk) begin
    dTop[0] <= topRe;
    dBot[0] <= botRe;
    for (int i = 1; i < LATENCY; i++) begin
      dTop[i] <= dTop[i-1];
      dBot[i] <= dBot[i-1];
    end
  end

  logic signed [AW-1:0] refRaw, refAdj;
  logic signed [DW-1:0] refSum;
  always_comb begin
    refRaw = AW'(dTop[LATENCY-1]) + AW'(dBot[LATENCY-1]);
    refAdj = HALVE ? ((refRaw + AW'(1)) >>> 1) : refRaw;
    if (refAdj > HI)      refSum = HI[DW-1:0];
    else if (refAdj < LO) refSum = LO[DW-1:0];
    else                  refSum = refAdj[DW-1:0];
  end

  // R4: a valid input comes out exactly four edges later
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##4 outValid);

  // R4: no output without a matching input
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 4));

  // R1 / R7: real sum matches the delayed inputs
  a_r1_sum_re: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sumRe == refSum));

  // R5: results hold while idle
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(sumRe) && $stable(sumIm) && $stable(rotRe) && $stable(rotIm)));

  // R6: reset clears the valid flag and results
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (!outValid && sumRe == '0 && sumIm == '0 && rotRe == '0 && rotIm == '0));
endmodule

bind dif_butterfly dif_butterfly_chk #(.DW(DW), .HALVE(HALVE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .topRe    (topRe),
  .botRe    (botRe),
  .outValid (outValid),
  .sumRe    (sumRe),
  .sumIm    (sumIm),
  .rotRe    (rotRe),
  .rotIm    (rotIm)
);

// File: tb/dif_butterfly_bench.sv
module dif_butterfly_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int CW  = 16;
  localparam int LAT = 4;
  localparam int NQ  = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                 inValid = 1'b0;
  logic signed [DW-1:0] topRe = '0, topIm = '0, botRe = '0, botIm = '0;
  logic signed [CW-1:0] twCos = '0;
  logic signed [CW:0]   twDiff = '0, twSum = '0;

  logic                 oValid [2];
  logic signed [DW-1:0] oSumRe [2], oSumIm [2], oRotRe [2], oRotIm [2];

  // index 0: halving enabled, index 1: unscaled
  dif_butterfly #(.DW(DW), .CW(CW), .HALVE(1'b1)) u_dif_butterfly (
    .clk(clk), .rst(rst), .inValid(inValid),
    .topRe(topRe), .topIm(topIm), .botRe(botRe), .botIm(botIm),
    .twCos(twCos), .twDiff(twDiff), .twSum(twSum),
    .outValid(oValid[0]), .sumRe(oSumRe[0]), .sumIm(oSumIm[0]),
    .rotRe(oRotRe[0]), .rotIm(oRotIm[0]));

  dif_butterfly #(.DW(DW), .CW(CW), .HALVE(1'b0)) u_dif_butterfly_full (
    .clk(clk), .rst(rst), .inValid(inValid),
    .topRe(topRe), .topIm(topIm), .botRe(botRe), .botIm(botIm),
    .twCos(twCos), .twDiff(twDiff), .twSum(twSum),
    .outValid(oValid[1]), .sumRe(oSumRe[1]), .sumIm(oSumIm[1]),
    .rotRe(oRotRe[1]), .rotIm(oRotIm[1]));

  int checks = 0, errors = 0, cyc = 0, wr = 0;
  int rd [2];
  int expv [2][NQ][4];
  bit clipped [2][NQ][4];
  int stamp [NQ];
  int prevv [2][4];
  bit timedOut = 1'b0;

  function automatic longint rsh(longint v, int sh);
    if (sh == 0) return v;
    return (v + (64'sd1 <<< (sh - 1))) >>> sh;
  endfunction

  function automatic int clampv(longint v, output bit c);
    longint hi = (64'sd1 <<< (DW - 1)) - 1;
    longint lo = -hi - 1;
    c = 1'b0;
    if (v > hi) begin c = 1'b1; return int'(hi); end
    if (v < lo) begin c = 1'b1; return int'(lo); end
    return int'(v);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // reference: direct four-product rotation, independent of the 3-mult form
  task automatic push(int tr, int ti, int br, int bi, int c, int s);
    longint a = longint'(tr) - br;
    longint b = longint'(ti) - bi;
    for (int d = 0; d < 2; d++) begin
      int h = (d == 0) ? 1 : 0;
      expv[d][wr][0] = clampv(rsh(longint'(tr) + br, h), clipped[d][wr][0]);
      expv[d][wr][1] = clampv(rsh(longint'(ti) + bi, h), clipped[d][wr][1]);
      expv[d][wr][2] = clampv(rsh(a * c - b * s, CW - 1 + h), clipped[d][wr][2]);
      expv[d][wr][3] = clampv(rsh(a * s + b * c, CW - 1 + h), clipped[d][wr][3]);
    end
    stamp[wr] = cyc;
    wr++;
  endtask

  task automatic observe();
    for (int d = 0; d < 2; d++) begin
      int cur [4];
      cur[0] = int'(oSumRe[d]); cur[1] = int'(oSumIm[d]);
      cur[2] = int'(oRotRe[d]); cur[3] = int'(oRotIm[d]);
      if (oValid[d]) begin
        if (rd[d] < wr) begin
          check(stamp[rd[d]] == cyc - LAT, "R4", "output latency", cyc - stamp[rd[d]], LAT);
          for (int k = 0; k < 4; k++) begin
            string req;
            if (clipped[d][rd[d]][k])  req = "R3";
            else if (d == 1)           req = "R7";
            else if (k < 2)            req = "R1";
            else                       req = "R2";
            check(cur[k] == expv[d][rd[d]][k], req,
                  (k == 0) ? "sumRe" : (k == 1) ? "sumIm" : (k == 2) ? "rotRe" : "rotIm",
                  cur[k], expv[d][rd[d]][k]);
          end
          rd[d]++;
        end else begin
          check(1'b0, "R4", "spurious outValid", 1, 0);
        end
      end else begin
        if (rd[d] < wr && stamp[rd[d]] <= cyc - LAT)
          check(1'b0, "R4", "missing outValid", 0, 1);
        for (int k = 0; k < 4; k++)
          check(cur[k] == prevv[d][k], "R5", "hold while idle", cur[k], prevv[d][k]);
      end
      for (int k = 0; k < 4; k++) prevv[d][k] = cur[k];
    end
  endtask

  task automatic step(bit v, int tr, int ti, int br, int bi, int c, int s);
    @(negedge clk);
    cyc++;
    observe();
    inValid = v;
    topRe = DW'(tr); topIm = DW'(ti); botRe = DW'(br); botIm = DW'(bi);
    twCos = CW'(c); twDiff = (CW+1)'(c - s); twSum = (CW+1)'(c + s);
    if (v) push(tr, ti, br, bi, c, s);
  endtask

  function automatic int rs16();
    return int'($signed(16'($urandom)));
  endfunction

  task automatic run();
    rd[0] = 0; rd[1] = 0;
    repeat (3) @(negedge clk);
    // R6: reset state
    for (int d = 0; d < 2; d++) begin
      check(oValid[d] == 1'b0, "R6", "outValid in reset", int'(oValid[d]), 0);
      check(oSumRe[d] == '0 && oSumIm[d] == '0 && oRotRe[d] == '0 && oRotIm[d] == '0,
            "R6", "results in reset", int'(oSumRe[d]), 0);
      for (int k = 0; k < 4; k++) prevv[d][k] = 0;
    end
    rst = 1'b0;
    // R3: saturating sums (unscaled) and exact max with halving
    step(1, 32767, 32767, 32767, 32767, 32767, 0);
    step(1, -32768, -32768, -32768, -32768, 32767, 0);
    // R3: rotation overflow from a full-scale difference
    step(1, 32767, -32768, -32768, 32767, 32767, 32767);
    step(1, 32767, -32768, -32768, 32767, -32768, -32768);
    // R1: rounding of +1 and -1 halves
    step(1, 1, -1, 0, 0, 0, 32767);
    step(1, -3, 3, 0, 0, -32768, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R2: pure imaginary rotation and small values
    step(1, 100, -50, -100, 50, 0, -32768);
    step(1, 7, 9, 3, -2, 23170, -23170);
    repeat (6) step(0, 0, 0, 0, 0, 0, 0);
    // R4 / R2 / R5: random bursts and gaps
    void'($urandom(32'd20251));
    for (int n = 0; n < 1500; n++) begin
      bit v = ($urandom % 10) < 7;
      step(v, rs16(), rs16(), rs16(), rs16(), rs16(), rs16());
    end
    repeat (8) step(0, 0, 0, 0, 0, 0, 0);
    // R4: everything issued came out
    check(rd[0] == wr, "R4", "drained count halved", rd[0], wr);
    check(rd[1] == wr, "R4", "drained count unscaled", rd[1], wr);
    // R6: reset mid-stream clears outputs
    step(1, 500, 500, 400, 400, 32767, 0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(oValid[0] == 1'b0 && oSumRe[0] == '0 && oRotRe[0] == '0, "R6",
          "reset mid-stream", int'(oSumRe[0]), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (200000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired actual=hung expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule